// File: doc/BRIEF.md
# Configurable Two-Port Synchronous RAM

A shared word array reached through two fully independent ports, each with its own clock, enable, byte-lane write strobes, address, write data, read data and synchronous output reset. Both ports can read and write any location, so the block serves as shared storage between two agents, as a mailbox, or as a lookup table that one side refills while the other side reads it.

Each port is fixed at elaboration to one of three read-during-write behaviours. In write-first the written word appears on the output. In read-first the output shows the word as it was before the write. In no-change the output keeps its last value. Each port also selects zero, one or two extra output register stages, a reset value for its output, whether reset or enable wins on those extra stages, and whether its enable pin is used at all. All locations start at one default word given as a parameter.

Top module: `tdp_ram`

## Requirements
- R1: A port in write-first mode (MODE=0) that writes presents the written word, merged with the untouched lanes of the old word, on its output after the normal read latency.
- R2: A port in read-first mode (MODE=1) that writes presents the contents of the location as they were before that write.
- R3: A port in no-change mode (MODE=2) keeps its first output stage unchanged in every cycle in which it writes; reads afterwards return the new word.
- R4: With the port enable low, the port performs no write, no read and no reset of its first output stage. With HAS_EN=0 the enable pin is ignored and the port is always active.
- R5: An active port with its reset high drives its read output to its RST_VAL on the next cycle. Memory contents are untouched by reset.
- R6: Write strobe bit k writes bits [k*LANE_W +: LANE_W] of the word only. LANE_W is 8, or 9 with parity, and DATA_W is a whole multiple of LANE_W.
- R7: With OUT_REGS set to 0, 1 or 2, read data appears 1, 2 or 3 clock edges after the address is sampled. Reset and enable act on every stage, so one reset clears the whole output pipeline.
- R8: With RST_WINS=1, reset clears the extra output stages even while the enable is low. With RST_WINS=0, reset acts on them only while the enable is high.
- R9: Every location holds INIT_VAL before it is first written, and the array is at least two words deep (ADDR_W of at least 1).
- R10: A word written through one port can be read through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| rst_a | input | 1 | Port A synchronous output reset |
| we_a | input | DATA_W/LANE_W | Port A write strobes, one per lane |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | DATA_W | Port A write data |
| rdata_a | output | DATA_W | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| rst_b | input | 1 | Port B synchronous output reset |
| we_b | input | DATA_W/LANE_W | Port B write strobes, one per lane |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | DATA_W | Port B write data |
| rdata_b | output | DATA_W | Port B read data |

## Verification
The assertions check every cycle that an idle port's output stays still, that reset lands on the programmed value, that reset priority on the extra stages follows RST_WINS, and that unregistered write-first and no-change ports echo or hold as required. What was stored, and where, can only be shown by the bench scenarios. They cover byte-lane merging, read-first returning old contents, words crossing from one port to the other, the initial contents, and the exact latency of each pipeline depth. A bench model of the array and the output stages is compared against both ports of two differently configured instances.

// File: rtl/tdp_ram.sv
module tdp_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0,
  parameter int MODE_A = 0,
  parameter int MODE_B = 0,
  parameter int OUT_REGS_A = 0,
  parameter int OUT_REGS_B = 0,
  parameter bit RST_WINS_A = 1'b1,
  parameter bit RST_WINS_B = 1'b1,
  parameter bit HAS_EN_A = 1'b1,
  parameter bit HAS_EN_B = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL_A = '0,
  parameter logic [DATA_W-1:0] RST_VAL_B = '0
) (
  input  logic                       clk_a,
  input  logic                       en_a,
  input  logic                       rst_a,
  input  logic [DATA_W/LANE_W-1:0]   we_a,
  input  logic [ADDR_W-1:0]          addr_a,
  input  logic [DATA_W-1:0]          wdata_a,
  output logic [DATA_W-1:0]          rdata_a,
  input  logic                       clk_b,
  input  logic                       en_b,
  input  logic                       rst_b,
  input  logic [DATA_W/LANE_W-1:0]   we_b,
  input  logic [ADDR_W-1:0]          addr_b,
  input  logic [DATA_W-1:0]          wdata_b,
  output logic [DATA_W-1:0]          rdata_b
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WR_FIRST = 0;
  localparam int RD_FIRST = 1;

  // Word value = bank_a ^ bank_b; each bank has exactly one writing port.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_a[i] = INIT_VAL;
      bank_b[i] = '0;
    end
  end

  logic act_a, act_b;
  logic [DATA_W-1:0] cur_a, cur_b, mix_a, mix_b;

  assign act_a = HAS_EN_A ? en_a : 1'b1;
  assign act_b = HAS_EN_B ? en_b : 1'b1;
  assign cur_a = bank_a[addr_a] ^ bank_b[addr_a];
  assign cur_b = bank_a[addr_b] ^ bank_b[addr_b];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mix_a[l*LANE_W +: LANE_W] = we_a[l] ? wdata_a[l*LANE_W +: LANE_W] : cur_a[l*LANE_W +: LANE_W];
    assign mix_b[l*LANE_W +: LANE_W] = we_b[l] ? wdata_b[l*LANE_W +: LANE_W] : cur_b[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_a)
    if (act_a && (|we_a)) bank_a[addr_a] <= mix_a ^ bank_b[addr_a];

  always_ff @(posedge clk_b)
    if (act_b && (|we_b)) bank_b[addr_b] <= mix_b ^ bank_a[addr_b];

  logic [DATA_W-1:0] pipe_a [OUT_REGS_A+1];
  logic [DATA_W-1:0] pipe_b [OUT_REGS_B+1];

  always_ff @(posedge clk_a) begin
    if (act_a) begin
      if (rst_a)                pipe_a[0] <= RST_VAL_A;
      else if (!(|we_a))        pipe_a[0] <= cur_a;
      else if (MODE_A == WR_FIRST) pipe_a[0] <= mix_a;
      else if (MODE_A == RD_FIRST) pipe_a[0] <= cur_a;
    end
    for (int k = 1; k <= OUT_REGS_A; k++) begin
      if (rst_a && (RST_WINS_A || act_a)) pipe_a[k] <= RST_VAL_A;
      else if (act_a)                     pipe_a[k] <= pipe_a[k-1];
    end
  end

  always_ff @(posedge clk_b) begin
    if (act_b) begin
      if (rst_b)                pipe_b[0] <= RST_VAL_B;
      else if (!(|we_b))        pipe_b[0] <= cur_b;
      else if (MODE_B == WR_FIRST) pipe_b[0] <= mix_b;
      else if (MODE_B == RD_FIRST) pipe_b[0] <= cur_b;
    end
    for (int k = 1; k <= OUT_REGS_B; k++) begin
      if (rst_b && (RST_WINS_B || act_b)) pipe_b[k] <= RST_VAL_B;
      else if (act_b)                     pipe_b[k] <= pipe_b[k-1];
    end
  end

  assign rdata_a = pipe_a[OUT_REGS_A];
  assign rdata_b = pipe_b[OUT_REGS_B];
endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_port_chk #(
  parameter int DATA_W = 32,
  parameter int LANES = 4,
  parameter int MODE = 0,
  parameter int OUT_REGS = 0,
  parameter bit RST_WINS = 1'b1,
  parameter bit HAS_EN = 1'b1,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              en,
  input logic              rst,
  input logic [LANES-1:0]  we,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  logic act;
  bit primed = 1'b0;
  assign act = HAS_EN ? en : 1'b1;

  always_ff @(posedge clk)
    if (rst && act) primed <= 1'b1;

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!primed)
    (!act && !rst) |=> $stable(rdata));

  a_r5_reset_value: assert property (@(posedge clk) disable iff (!primed)
    (act && rst) |=> (rdata == RST_VAL));

  a_r8_reset_wins: assert property (@(posedge clk) disable iff (!primed)
    (RST_WINS && OUT_REGS > 0 && rst && !act) |=> (rdata == RST_VAL));

  a_r8_enable_wins: assert property (@(posedge clk) disable iff (!primed)
    (!RST_WINS && rst && !act) |=> $stable(rdata));

  a_r3_nochange_hold: assert property (@(posedge clk) disable iff (!primed)
    (MODE == 2 && OUT_REGS == 0 && act && !rst && (|we)) |=> $stable(rdata));

  a_r1_write_first_echo: assert property (@(posedge clk) disable iff (!primed)
    (MODE == 0 && OUT_REGS == 0 && act && !rst && (&we)) |=> (rdata == $past(wdata)));
endmodule

bind tdp_ram tdp_ram_port_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .MODE(MODE_A), .OUT_REGS(OUT_REGS_A),
  .RST_WINS(RST_WINS_A), .HAS_EN(HAS_EN_A), .RST_VAL(RST_VAL_A)
) u_chk_a (.clk(clk_a), .en(en_a), .rst(rst_a), .we(we_a), .wdata(wdata_a), .rdata(rdata_a));

bind tdp_ram tdp_ram_port_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .MODE(MODE_B), .OUT_REGS(OUT_REGS_B),
  .RST_WINS(RST_WINS_B), .HAS_EN(HAS_EN_B), .RST_VAL(RST_VAL_B)
) u_chk_b (.clk(clk_b), .en(en_b), .rst(rst_b), .we(we_b), .wdata(wdata_b), .rdata(rdata_b));

// File: tb/tdp_ram_tb.sv
`timescale 1ns/1ps
module tdp_ram_tb;
  // ports 0,1 = u_dut A,B ; ports 2,3 = u_dut_p A,B
  localparam int MODE_T[4]  = '{0, 1, 2, 0};
  localparam int OREG_T[4]  = '{0, 2, 1, 0};
  localparam int WINS_T[4]  = '{1, 1, 0, 1};
  localparam int HASEN_T[4] = '{1, 1, 1, 0};
  localparam int LW_T[4]    = '{8, 8, 9, 9};
  localparam int DEP_T[4]   = '{32, 32, 16, 16};
  localparam logic [35:0] RV_T[4] = '{36'hDEADBEEF, 36'h12345678, 36'hF0000000F, 36'h0};
  localparam logic [35:0] INIT0 = 36'hA5A50F0F;
  localparam logic [35:0] INIT1 = 36'h3C3C3C3C3;

  bit clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        en [4];
  logic        rst [4];
  logic [3:0]  we [4];
  logic [4:0]  addr [4];
  logic [35:0] wd [4];
  logic [31:0] rd0a, rd0b;
  logic [35:0] rd1a, rd1b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  tdp_ram #(.DATA_W(32), .ADDR_W(5), .LANE_W(8), .INIT_VAL(32'hA5A50F0F),
    .MODE_A(0), .MODE_B(1), .OUT_REGS_A(0), .OUT_REGS_B(2),
    .RST_WINS_A(1'b1), .RST_WINS_B(1'b1), .HAS_EN_A(1'b1), .HAS_EN_B(1'b1),
    .RST_VAL_A(32'hDEADBEEF), .RST_VAL_B(32'h12345678)) u_dut (
    .clk_a(clk), .en_a(en[0]), .rst_a(rst[0]), .we_a(we[0]), .addr_a(addr[0]),
    .wdata_a(wd[0][31:0]), .rdata_a(rd0a),
    .clk_b(clk), .en_b(en[1]), .rst_b(rst[1]), .we_b(we[1]), .addr_b(addr[1]),
    .wdata_b(wd[1][31:0]), .rdata_b(rd0b));

  tdp_ram #(.DATA_W(36), .ADDR_W(4), .LANE_W(9), .INIT_VAL(36'h3C3C3C3C3),
    .MODE_A(2), .MODE_B(0), .OUT_REGS_A(1), .OUT_REGS_B(0),
    .RST_WINS_A(1'b0), .RST_WINS_B(1'b1), .HAS_EN_A(1'b1), .HAS_EN_B(1'b0),
    .RST_VAL_A(36'hF0000000F), .RST_VAL_B(36'h0)) u_dut_p (
    .clk_a(clk), .en_a(en[2]), .rst_a(rst[2]), .we_a(we[2]), .addr_a(addr[2][3:0]),
    .wdata_a(wd[2]), .rdata_a(rd1a),
    .clk_b(clk), .en_b(en[3]), .rst_b(rst[3]), .we_b(we[3]), .addr_b(addr[3][3:0]),
    .wdata_b(wd[3]), .rdata_b(rd1b));

  // reference model
  logic [35:0] mref [2][32];
  logic [35:0] st [4][3];

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] w, int lw);
    logic [35:0] r = old;
    for (int l = 0; l < 4; l++)
      for (int b = 0; b < lw; b++)
        if (w[l]) r[l*lw+b] = nw[l*lw+b];
    return r;
  endfunction

  function automatic logic [35:0] dmask(int p);
    return (p < 2) ? 36'h0FFFFFFFF : 36'hFFFFFFFFF;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin
      mref[0][i] = INIT0;
      mref[1][i] = INIT1;
    end
  end

  always @(posedge clk) begin : model
    logic [35:0] cur [4];
    logic [35:0] nxt [4];
    logic a;
    int ad;
    for (int p = 0; p < 4; p++) begin
      ad = int'(addr[p]) % DEP_T[p];
      cur[p] = mref[p/2][ad];
      nxt[p] = merge(cur[p], wd[p] & dmask(p), we[p], LW_T[p]);
    end
    for (int p = 0; p < 4; p++) begin
      a = (HASEN_T[p] != 0) ? en[p] : 1'b1;
      for (int k = 2; k >= 1; k--)
        if (k <= OREG_T[p]) begin
          if (rst[p] && (WINS_T[p] != 0 || a)) st[p][k] = RV_T[p];
          else if (a) st[p][k] = st[p][k-1];
        end
      if (a) begin
        if (rst[p]) st[p][0] = RV_T[p];
        else if (we[p] == 4'b0) st[p][0] = cur[p];
        else if (MODE_T[p] == 0) st[p][0] = nxt[p];
        else if (MODE_T[p] == 1) st[p][0] = cur[p];
      end
    end
    for (int p = 0; p < 4; p++) begin
      a = (HASEN_T[p] != 0) ? en[p] : 1'b1;
      if (a && we[p] != 4'b0) mref[p/2][int'(addr[p]) % DEP_T[p]] = nxt[p];
    end
  end

  function automatic logic [35:0] out_of(int p);
    case (p)
      0: return {4'b0, rd0a};
      1: return {4'b0, rd0b};
      2: return rd1a;
      default: return rd1b;
    endcase
  endfunction

  task automatic expect_eq(string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    for (int p = 0; p < 4; p++) begin
      string t;
      if (tag != "") t = tag;
      else t = (MODE_T[p] == 0) ? "R1" : (MODE_T[p] == 1) ? "R2" : "R3";
      expect_eq($sformatf("%s model port %0d", t, p), out_of(p), st[p][OREG_T[p]]);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic idle_all();
    for (int p = 0; p < 4; p++) begin
      en[p] = 1'b1; rst[p] = 1'b0; we[p] = 4'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < 4; p++) begin
      en[p] = 1'b1; rst[p] = 1'b1; we[p] = 4'b0; addr[p] = '0; wd[p] = '0;
    end
    // R5: reset state
    step("R5");
    expect_eq("R5 reset A", {4'b0, rd0a}, 36'hDEADBEEF);
    expect_eq("R5 reset B (3-stage)", {4'b0, rd0b}, 36'h12345678);
    expect_eq("R5 reset parity A", rd1a, 36'hF0000000F);
    idle_all();

    // R9: initial contents at the last location
    for (int p = 0; p < 4; p++) addr[p] = 5'd31;
    step("R9"); step("R9"); step("R9");
    expect_eq("R9 init A", {4'b0, rd0a}, INIT0);
    expect_eq("R9 init parity B", rd1b, INIT1);
    expect_eq("R7 three-edge latency B", {4'b0, rd0b}, INIT0);

    // R1 / R7 / R10: write through A, read through B
    addr[0] = 5'd3; we[0] = 4'hF; wd[0] = 36'h11223344;
    addr[1] = 5'd3;
    step("R1");
    expect_eq("R1 write-first echo", {4'b0, rd0a}, 36'h11223344);
    we[0] = 4'b0;
    step("R7"); step("R7");
    expect_eq("R7 not yet visible", {4'b0, rd0b}, INIT0);
    step("R7");
    expect_eq("R10 cross-port read", {4'b0, rd0b}, 36'h11223344);

    // R6: lanes 0 and 2 only
    we[0] = 4'b0101; wd[0] = 36'hAABBCCDD;
    step("R6");
    expect_eq("R6 lane merge", {4'b0, rd0a}, 36'h11BB33DD);
    we[0] = 4'b0;

    // R2: read-first write on B returns old contents
    addr[1] = 5'd5; we[1] = 4'hF; wd[1] = 36'hCAFEF00D;
    step("R2");
    we[1] = 4'b0;
    step("R2"); step("R2");
    expect_eq("R2 read-first old word", {4'b0, rd0b}, INIT0);
    step("R2");
    expect_eq("R2 new word after write", {4'b0, rd0b}, 36'hCAFEF00D);

    // R3: no-change on parity port A
    addr[2] = 5'd2;
    step("R3"); step("R3");
    expect_eq("R3 before write", rd1a, INIT1);
    we[2] = 4'hF; wd[2] = 36'h123456789;
    step("R3"); step("R3");
    expect_eq("R3 hold during write", rd1a, INIT1);
    we[2] = 4'b0;
    step("R3"); step("R3");
    expect_eq("R3 new word after write", rd1a, 36'h123456789);

    // R4 / R8: enable low blocks write, read and reset (enable wins)
    addr[2] = 5'd7; en[2] = 1'b0; rst[2] = 1'b1; we[2] = 4'hF; wd[2] = 36'h000000123;
    step("R4"); step("R8");
    expect_eq("R8 enable-priority keeps output", rd1a, 36'h123456789);
    en[2] = 1'b1; rst[2] = 1'b0; we[2] = 4'b0;
    step("R4"); step("R4");
    expect_eq("R4 no write when disabled", rd1a, INIT1);

    // R8: reset wins on B's stages while disabled
    en[1] = 1'b0; rst[1] = 1'b1;
    step("R8");
    expect_eq("R8 reset-priority output", {4'b0, rd0b}, 36'h12345678);
    en[1] = 1'b1; rst[1] = 1'b0;

    // R4: port without enable pin stays active
    en[3] = 1'b0; addr[3] = 5'd9; we[3] = 4'hF; wd[3] = 36'h00000005A;
    step("R4");
    expect_eq("R4 always-enabled port writes", rd1b, 36'h00000005A);
    idle_all();
    step("R9");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 4; p++) begin
        en[p]   = ($urandom % 8) != 0;
        rst[p]  = ($urandom % 16) == 0;
        we[p]   = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0;
        addr[p] = 5'($urandom % 8);
        wd[p]   = {4'($urandom), 32'($urandom)};
      end
      for (int i = 0; i < 2; i++)
        if ((int'(addr[2*i]) % DEP_T[2*i]) == (int'(addr[2*i+1]) % DEP_T[2*i+1]) &&
            we[2*i] != 4'b0)
          we[2*i+1] = 4'b0;
      step("");
    end
    finish_run();
  end
endmodule